// File: doc/BRIEF.md
# Eight-Cell Configurable Logic Module

The block groups eight configurable logic cells into one unit that a routing fabric connects as a whole. Each cell holds a 4-input lookup table, a small control word and a user register. From these a cell produces a combinational function or a registered one, and it can act as one bit of an adder. The eight cells share a ripple carry path and a single serial configuration path. Both run through the cells in a fixed order, so the module can form adders of up to eight bits. A chain of such modules is loaded through one serial line and carries across module borders through the carry ports.

Each cell stores 32 bits, so the module stores 256. While the configuration enable is high, every stored bit moves one place along the chain on each clock. When it is low, the tables and control words hold and the user registers run. A three-level binary multiplexer tree over the eight cell results forms functions of up to seven inputs, with three select inputs acting as the extra function inputs. A final 2:1 multiplexer, driven by a fourth select input, picks between this module's tree result and a tree result from a peer module. Two modules together therefore reach eight-input functions.

Top module: `oct_module`

## Requirements
- R1: While the reset input is low, and for two clocks after it rises, every stored bit is zero. In that state every cell output, the tree output and the scan output read 0, and the carry output follows the carry input.
- R2: With the configuration enable high, each rising clock shifts the whole 256-bit chain one place. Bit 0 of cell 0 takes the scan input, cell k bit 31 feeds cell k+1 bit 0, and the scan output is cell 7 bit 31. A bit presented at the scan input appears at the scan output after exactly 256 rising edges. Cell k bit j is therefore the bit shifted in at step 255-(32k+j) of a load.
- R3: With the configuration enable low, table and control bits do not change whatever the scan input does.
- R4: Cell bit layout: bits 15:0 hold the table, 19:16 an input invert mask and 23:20 an input tie mask. The lookup index is (din AND NOT tie) XOR invert, and the cell result is the table bit at that index.
- R5: Bit 24 enables arithmetic. In that mode the cell result is the table bit XOR the carry into the cell. The carry out is the carry in when the table bit is 1, and index bit 0 otherwise. Eight cells with table 16'h6666, with a on input 0 and b on input 1, add a+b+carry_in: the sum appears on the cell outputs and bit 8 on the carry output.
- R6: Bit 25 set makes the cell ignore its incoming carry and use bit 26 as its carry in.
- R7: A cell with bit 24 clear passes its carry in (after R6) unchanged to its carry out.
- R8: Bit 27 set makes the cell output show the user register. With the configuration enable low, the user register takes the cell result on each rising clock.
- R9: Bit 31 is the user register, so a load sets its start value. Bit 28 set freezes the register while the configuration enable is low.
- R10: Bit 30 set inverts the cell output (after the R8 choice); it does not change the tree leaf or the carry.
- R11: The tree output equals the leaf of cell number xsel[2:0]. A leaf is the cell result, or the user register when bit 29 is set.
- R12: The wide output equals the peer input when xsel[3] is 1, and the tree output when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Serial configuration output (cell 7 bit 31) |
| cell_in | input | 32 | Four function inputs per cell, cell k at bits 4k+3:4k |
| carry_in | input | 1 | Carry into cell 0 |
| carry_out | output | 1 | Carry out of cell 7 |
| xsel | input | 4 | Tree selects (bits 2:0) and peer select (bit 3) |
| exp_peer | input | 1 | Tree result of a neighbouring module |
| cell_out | output | 8 | Per-cell outputs |
| exp_out | output | 1 | Tree result of this module |
| exp_wide | output | 1 | Result after the peer multiplexer |

## Verification
All eight tables are loaded with a 4-input XOR, and random inputs are compared with a parity model. This shows whether the index is formed from the right input bits in every cell. Per-cell distinct tables, swept over all tree selects, separate a wrong tree leaf from a wrong table bit. The adder is driven with all-zero operands, full-ones operands with carry, an all-ones plus one that must ripple through every cell, and random values. These show whether the carry generate, propagate and chain order are correct. A 256-bit readback of a pattern with a set top bit pins the scan latency to exactly 256 edges and confirms the bit order.

// File: rtl/oct_pkg.sv
package oct_pkg;
  localparam int LUT_K = 4;
  localparam int LUT_N = 1 << LUT_K;

  typedef struct packed {
    logic             out_inv;
    logic             leaf_reg;
    logic             hold;
    logic             reg_out;
    logic             start_val;
    logic             start_en;
    logic             arith;
    logic [LUT_K-1:0] tie;
    logic [LUT_K-1:0] inv;
  } cell_ctl_t;

  localparam int CTL_W  = $bits(cell_ctl_t);
  localparam int CFG_W  = LUT_N + CTL_W;
  localparam int CELL_W = CFG_W + 1;
endpackage

// File: rtl/oct_rst_sync.sv
module oct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/oct_cell.sv
module oct_cell
  import oct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic [LUT_K-1:0]  din,
  input  logic              carry_in,
  output logic              carry_out,
  output logic              f_out,
  output logic              leaf_out,
  output logic              cell_out,
  output logic [CELL_W-1:0] state_q
);
  logic [LUT_N-1:0] lut_q, lut_d;
  cell_ctl_t        ctl_q, ctl_d;
  logic             ureg_q, ureg_d;
  logic             cfg_ld;
  logic             ureg_en;
  logic [LUT_K-1:0] idx;
  logic             lut_bit;
  logic             cin_eff;

  assign state_q = {ureg_q, ctl_q, lut_q};

  // function and carry
  always_comb begin
    idx     = (din & ~ctl_q.tie) ^ ctl_q.inv;
    lut_bit = lut_q[idx];
    cin_eff = ctl_q.start_en ? ctl_q.start_val : carry_in;
    if (ctl_q.arith) begin
      f_out     = lut_bit ^ cin_eff;
      carry_out = lut_bit ? cin_eff : idx[0];
    end else begin
      f_out     = lut_bit;
      carry_out = cin_eff;
    end
  end

  always_comb begin
    leaf_out = ctl_q.leaf_reg ? ureg_q : f_out;
    cell_out = (ctl_q.reg_out ? ureg_q : f_out) ^ ctl_q.out_inv;
    scan_out = ureg_q;
  end

  // next state and clock enables
  always_comb begin
    cfg_ld  = cfg_en;
    ureg_en = cfg_en | ~ctl_q.hold;
    lut_d   = lut_q;
    ctl_d   = ctl_q;
    ureg_d  = ureg_q;
    if (cfg_en) begin
      {ureg_d, ctl_d, lut_d} = {state_q[CELL_W-2:0], scan_in};
    end else begin
      ureg_d = f_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lut_q  <= '0;
      ctl_q  <= '0;
      ureg_q <= 1'b0;
    end else begin
      if (cfg_ld) begin
        lut_q <= lut_d;
        ctl_q <= ctl_d;
      end
      if (ureg_en) begin
        ureg_q <= ureg_d;
      end
    end
  end
endmodule

// File: rtl/oct_xtree.sv
module oct_xtree #(
  parameter  int N_LEAF = 8,
  localparam int SEL_W  = $clog2(N_LEAF)
) (
  input  logic [N_LEAF-1:0] leaf,
  input  logic [SEL_W-1:0]  sel,
  output logic              root
);
  for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
    logic [(N_LEAF>>(l+1))-1:0] v;
    logic [(N_LEAF>>l)-1:0]     src;
    if (l == 0) begin : g_first
      assign src = leaf;
    end else begin : g_next
      assign src = g_lvl[l-1].v;
    end
    for (genvar j = 0; j < (N_LEAF >> (l+1)); j++) begin : g_mux
      assign v[j] = sel[l] ? src[2*j+1] : src[2*j];
    end
  end

  assign root = g_lvl[SEL_W-1].v[0];
endmodule

// File: rtl/oct_module.sv
module oct_module
  import oct_pkg::*;
#(
  parameter  int N_CELLS = 8,
  localparam int XSEL_W  = $clog2(N_CELLS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_en,
  input  logic                     scan_in,
  output logic                     scan_out,
  input  logic [N_CELLS*LUT_K-1:0] cell_in,
  input  logic                     carry_in,
  output logic                     carry_out,
  input  logic [XSEL_W:0]          xsel,
  input  logic                     exp_peer,
  output logic [N_CELLS-1:0]       cell_out,
  output logic                     exp_out,
  output logic                     exp_wide
);
  localparam int CHAIN_W = N_CELLS * CELL_W;

  logic                rst_q_n;
  logic [N_CELLS:0]    cy;
  logic [N_CELLS:0]    sc;
  logic [N_CELLS-1:0]  f_v;
  logic [N_CELLS-1:0]  leaf;
  logic [CHAIN_W-1:0]  chain_flat;

  oct_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign cy[0] = carry_in;
  assign sc[0] = scan_in;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    oct_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .cfg_en    (cfg_en),
      .scan_in   (sc[k]),
      .scan_out  (sc[k+1]),
      .din       (cell_in[k*LUT_K +: LUT_K]),
      .carry_in  (cy[k]),
      .carry_out (cy[k+1]),
      .f_out     (f_v[k]),
      .leaf_out  (leaf[k]),
      .cell_out  (cell_out[k]),
      .state_q   (chain_flat[k*CELL_W +: CELL_W])
    );
  end

  oct_xtree #(.N_LEAF(N_CELLS)) u_tree (
    .leaf (leaf),
    .sel  (xsel[XSEL_W-1:0]),
    .root (exp_out)
  );

  always_comb begin
    exp_wide  = xsel[XSEL_W] ? exp_peer : exp_out;
    carry_out = cy[N_CELLS];
    scan_out  = sc[N_CELLS];
  end
endmodule

// File: rtl/oct_module_chk.sv
module oct_module_chk
  import oct_pkg::*;
#(
  parameter  int N_CELLS = 8,
  localparam int XSEL_W  = $clog2(N_CELLS),
  localparam int CHAIN_W = N_CELLS * CELL_W
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               cfg_en,
  input logic               scan_in,
  input logic [XSEL_W:0]    xsel,
  input logic [CHAIN_W-1:0] chain_flat,
  input logic [N_CELLS-1:0] leaf,
  input logic               exp_out,
  input logic               exp_wide,
  input logic               exp_peer,
  input logic               carry_in,
  input logic               carry_out
);
  logic [N_CELLS*CFG_W-1:0] cfg_only;
  logic [N_CELLS-1:0]       arith_v;
  logic [N_CELLS-1:0]       start_v;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_view
    cell_ctl_t c;
    assign c = chain_flat[k*CELL_W + LUT_N +: CTL_W];
    assign cfg_only[k*CFG_W +: CFG_W] = chain_flat[k*CELL_W +: CFG_W];
    assign arith_v[k] = c.arith;
    assign start_v[k] = c.start_en;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_q_n |-> chain_flat == '0); // R1

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    cfg_en |=> chain_flat == {$past(chain_flat[CHAIN_W-2:0]), $past(scan_in)}); // R2

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    !cfg_en |=> $stable(cfg_only)); // R3

  AST_CARRY_PASS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (arith_v == '0 && start_v == '0) |-> carry_out == carry_in); // R7

  AST_TREE_PICK: assert property (@(posedge clk) disable iff (!rst_q_n)
    exp_out == leaf[xsel[XSEL_W-1:0]]); // R11

  AST_WIDE_PEER: assert property (@(posedge clk) disable iff (!rst_q_n)
    xsel[XSEL_W] |-> exp_wide == exp_peer); // R12
endmodule

bind oct_module oct_module_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .cfg_en     (cfg_en),
  .scan_in    (scan_in),
  .xsel       (xsel),
  .chain_flat (chain_flat),
  .leaf       (leaf),
  .exp_out    (exp_out),
  .exp_wide   (exp_wide),
  .exp_peer   (exp_peer),
  .carry_in   (carry_in),
  .carry_out  (carry_out)
);

// File: tb/oct_module_bench.sv
module oct_module_bench;
  localparam int NC = 8;
  localparam int CW = 256;

  logic          clk;
  logic          rst_n;
  logic          cfg_en;
  logic          scan_in;
  logic          scan_out;
  logic [31:0]   cell_in;
  logic          carry_in;
  logic          carry_out;
  logic [3:0]    xsel;
  logic          exp_peer;
  logic [7:0]    cell_out;
  logic          exp_out;
  logic          exp_wide;

  int n_chk = 0;
  int n_bad = 0;
  logic [CW-1:0] cfgv;

  oct_module u_oct_module (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .scan_in(scan_in),
    .scan_out(scan_out), .cell_in(cell_in), .carry_in(carry_in),
    .carry_out(carry_out), .xsel(xsel), .exp_peer(exp_peer),
    .cell_out(cell_out), .exp_out(exp_out), .exp_wide(exp_wide)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {ureg, oinv, xreg, hold, rego, sval, sen, arith, tie, inv, lut}
  function automatic logic [31:0] mk(input logic [15:0] lut, input logic [3:0] inv,
      input logic [3:0] tie, input logic arith, input logic sen, input logic sval,
      input logic rego, input logic hold, input logic xreg, input logic oinv,
      input logic ureg);
    return {ureg, oinv, xreg, hold, rego, sval, sen, arith, tie, inv, lut};
  endfunction

  function automatic logic [31:0] adder_in(input logic [7:0] a, input logic [7:0] b);
    logic [31:0] r = '0;
    for (int k = 0; k < NC; k++) begin
      r[4*k]   = a[k];
      r[4*k+1] = b[k];
    end
    return r;
  endfunction

  task automatic load(input logic [CW-1:0] v);
    for (int i = CW-1; i >= 0; i--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      scan_in = v[i];
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    scan_in = 1'b0;
  endtask

  task automatic t_reset();
    carry_in = 1'b1;
    xsel     = 4'd0;
    #1;
    chk("R1 cell_out", {24'd0, cell_out}, 32'd0);
    chk("R1 scan_out", {31'd0, scan_out}, 32'd0);
    chk("R1 exp_out", {31'd0, exp_out}, 32'd0);
    chk("R1 exp_wide", {31'd0, exp_wide}, 32'd0);
    chk("R1 carry follows", {31'd0, carry_out}, 32'd1);
    carry_in = 1'b0;
    #1;
    chk("R1 carry follows 0", {31'd0, carry_out}, 32'd0);
  endtask

  task automatic t_scan_readback();
    logic [CW-1:0] v;
    for (int i = 0; i < CW/32; i++) v[32*i +: 32] = $urandom;
    v[CW-1] = 1'b1;
    for (int i = 0; i < 2*CW; i++) begin
      @(negedge clk);
      if (i == CW-1) chk("R2 not yet at 255 edges", {31'd0, scan_out}, 32'd0);
      if (i >= CW) chk("R2 readback", {31'd0, scan_out}, {31'd0, v[2*CW-1-i]});
      cfg_en  = 1'b1;
      scan_in = (i < CW) ? v[CW-1-i] : 1'b0;
    end
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic t_xor4();
    for (int k = 0; k < NC; k++) cfgv[32*k +: 32] = mk(16'h6996, 4'h0, 4'h0, 0,0,0,0,0,0,0,0);
    load(cfgv);
    for (int t = 0; t < 24; t++) begin
      logic [7:0] e;
      @(negedge clk);
      cell_in = $urandom;
      scan_in = t[0];          // R3: scan input toggles with enable low
      xsel    = 4'(t % 8);
      carry_in = t[1];
      #1;
      for (int k = 0; k < NC; k++) e[k] = ^cell_in[4*k +: 4];
      chk("R4 xor4 cells", {24'd0, cell_out}, {24'd0, e});
      chk("R11 xor4 tree", {31'd0, exp_out}, {31'd0, e[t % 8]});
      chk("R7 carry pass", {31'd0, carry_out}, {31'd0, carry_in});
    end
    repeat (20) begin
      @(negedge clk);
      scan_in = ~scan_in;
    end
    cell_in = 32'hFFFF_FFFF;
    #1;
    chk("R3 config held", {24'd0, cell_out}, 32'd0);
  endtask

  task automatic t_invtie();
    cfgv = '0;
    cfgv[31:0]  = mk(16'h8000, 4'hF, 4'h0, 0,0,0,0,0,0,0,0);
    cfgv[63:32] = mk(16'h8000, 4'h3, 4'h3, 0,0,0,0,0,0,0,0);
    load(cfgv);
    for (int t = 0; t < 16; t++) begin
      logic e0, e1;
      cell_in = {24'd0, 4'(t), 4'(t)};
      #1;
      e0 = (t == 0);
      e1 = t[2] & t[3];
      chk("R4 invert mask", {31'd0, cell_out[0]}, {31'd0, e0});
      chk("R4 tie mask", {31'd0, cell_out[1]}, {31'd0, e1});
    end
  endtask

  task automatic t_adder(input logic start);
    logic [7:0] av [6] = '{8'd0, 8'd255, 8'd255, 8'd170, 8'd200, 8'd0};
    logic [7:0] bv [6] = '{8'd0, 8'd1, 8'd255, 8'd85, 8'd100, 8'd0};
    for (int k = 0; k < NC; k++)
      cfgv[32*k +: 32] = mk(16'h6666, 4'h0, 4'h0, 1, (k == 0) & start, start, 0,0,0,0,0);
    load(cfgv);
    for (int t = 0; t < 14; t++) begin
      logic [7:0] a, b;
      logic ci;
      logic [8:0] s;
      if (t < 6) begin a = av[t]; b = bv[t]; end
      else begin a = 8'($urandom); b = 8'($urandom); end
      ci = t[0];
      cell_in  = adder_in(a, b);
      carry_in = ci;
      #1;
      s = {1'b0, a} + {1'b0, b} + {8'd0, (start ? 1'b1 : ci)};
      if (start) begin
        chk("R6 start sum", {24'd0, cell_out}, {24'd0, s[7:0]});
        chk("R6 start carry", {31'd0, carry_out}, {31'd0, s[8]});
      end else begin
        chk("R5 sum", {24'd0, cell_out}, {24'd0, s[7:0]});
        chk("R5 carry", {31'd0, carry_out}, {31'd0, s[8]});
      end
    end
  endtask

  task automatic t_expand();
    logic [15:0] lt [NC];
    cfgv = '0;
    for (int k = 0; k < NC; k++) begin
      lt[k] = 16'((32'h9E37 * (k + 3)) ^ (k << 9));
      cfgv[32*k +: 32] = mk(lt[k], 4'h0, 4'h0, 0,0,0,0,0,0,0,0);
    end
    load(cfgv);
    for (int t = 0; t < 16; t++) begin
      cell_in = $urandom;
      for (int s = 0; s < NC; s++) begin
        logic e;
        xsel = {1'b0, 3'(s)};
        exp_peer = ~t[0];
        #1;
        e = lt[s][cell_in[4*s +: 4]];
        chk("R11 tree leaf", {31'd0, exp_out}, {31'd0, e});
        chk("R12 wide local", {31'd0, exp_wide}, {31'd0, e});
        xsel[3] = 1'b1;
        #1;
        chk("R12 wide peer", {31'd0, exp_wide}, {31'd0, exp_peer});
      end
    end
  endtask

  task automatic t_ureg();
    cfgv = '0;
    cfgv[31:0]   = mk(16'h6996, 4'h0, 4'h0, 0,0,0, 1,0,0,0, 1);
    cfgv[63:32]  = mk(16'hFFFF, 4'h0, 4'h0, 0,0,0, 1,1,0,0, 0);
    cfgv[95:64]  = mk(16'h6996, 4'h0, 4'h0, 0,0,0, 0,0,0,1, 0);
    cfgv[127:96] = mk(16'h6996, 4'h0, 4'h0, 0,0,0, 0,0,1,0, 1);
    load(cfgv);
    cell_in = 32'd0;
    xsel    = 4'd3;
    #1;
    chk("R9 loaded ureg", {31'd0, cell_out[0]}, 32'd1);
    chk("R9 held ureg", {31'd0, cell_out[1]}, 32'd0);
    chk("R10 out invert", {31'd0, cell_out[2]}, 32'd1);
    chk("R11 reg leaf", {31'd0, exp_out}, 32'd1);
    chk("R11 cell3 comb out", {31'd0, cell_out[3]}, 32'd0);
    @(negedge clk);
    chk("R8 capture 0", {31'd0, cell_out[0]}, 32'd0);
    chk("R9 hold keeps", {31'd0, cell_out[1]}, 32'd0);
    chk("R11 reg leaf capture", {31'd0, exp_out}, 32'd0);
    cell_in = 32'h0000_0101;
    #1;
    chk("R8 no comb path", {31'd0, cell_out[0]}, 32'd0);
    chk("R10 out invert f=1", {31'd0, cell_out[2]}, 32'd0);
    @(negedge clk);
    chk("R8 capture 1", {31'd0, cell_out[0]}, 32'd1);
    chk("R9 hold still", {31'd0, cell_out[1]}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; scan_in = 1'b0; cell_in = '0;
    carry_in = 1'b0; xsel = '0; exp_peer = 1'b0; cfgv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_scan_readback();
    t_xor4();
    t_invtie();
    t_adder(1'b0);
    t_adder(1'b1);
    t_expand();
    t_ureg();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule